// File: doc/BRIEF.md
# Programmable CRC-32 Register Peripheral

This block is a register-mapped checksum engine for a simple 32-bit write/read bus with per-byte strobes. Software programs a starting value and a generator polynomial, then picks how incoming bits are reordered and whether the readback is bit-reversed. Data is pushed into the data register as full words or as single bytes, and the running checksum is read back from the same address. Each accepted data write folds its bits into the accumulator in a single clock.

A control write that sets the load bit copies the starting value into the accumulator. A control write without it changes only the reordering settings, so one calculation can span several mode changes. Word and byte pushes may be freely interleaved. Software applies any final inversion itself. Because the polynomial is fully writable, the same hardware covers both the common Ethernet CRC-32 and the Castagnoli variant.

Top module: `crc_regblock`

## Requirements
- R1: After reset, the start-value register (offset 0x10) reads 0xFFFFFFFF, the polynomial register (offset 0x14) reads 0x04C11DB7, the control register (offset 0x08) reads 0, and the data register (offset 0x00) reads 0xFFFFFFFF.
- R2: A control write with strobe lane 0 set and data bit 0 equal to 1 loads the start-value register into the accumulator on that edge. Control bit 0 always reads back as 0, and control bits 4:1 and 31:8 read as 0.
- R3: A data write with all four strobes set folds all 32 bits of the (reordered) word into the accumulator, most significant bit first. For each bit d, with fb = acc[31] ^ d, the new acc is (acc << 1) ^ (fb ? poly : 0).
- R4: A data write with exactly one strobe set folds only that lane's 8 bits, most significant bit first, using the same rule. Byte and word writes may be mixed without reloading.
- R5: Control bits 6:5 select input reordering for word writes: 00 keeps the order, 01 reverses the bits in each byte, 10 reverses the bits in each 16-bit half, and 11 reverses all 32 bits. For a byte write, any nonzero setting reverses the bits of that byte.
- R6: Control bit 7 set makes a data-register read return the accumulator with its 32 bits reversed; when it is clear, the read returns the accumulator unchanged.
- R7: A control write with bit 0 clear updates bits 7:5 and leaves the accumulator unchanged.
- R8: Writes to any offset other than 0x00, 0x08, 0x10 and 0x14 change no state, and reads from such offsets return 0. Data writes whose strobe is neither all ones nor one-hot leave the accumulator unchanged.
- R9: Reading any register has no side effect on the accumulator.
- R10: Writes to the start-value and polynomial registers update only the byte lanes whose strobe is set.
- R11: With start value 0xFFFFFFFF, control 0xE1, and byte writes of the ASCII string "123456789", the data register reads 0x340BC6D9 with polynomial 0x04C11DB7 and 0x1CF96D7C with polynomial 0x1EDC6F41. These are the bitwise inverses of the standard check values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 32 | Write data, byte lanes in natural positions |
| wr_strb | input | 4 | Per-lane write strobes |
| rd_addr | input | 5 | Byte address of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
The bench builds the block with its default 32-bit data path and 5-bit address. At that size it can sweep every one of the four input-reordering settings against both output settings, using long mixed sequences of word and byte pushes on every lane. It also drives all 256 byte values through the byte path and exercises every strobe pattern class on the data register. A bench-side bit-serial reference, together with the two published check strings, fixes the expected readback.

// File: rtl/crc_reg_pkg.sv
package crc_reg_pkg;

   // Input reordering selection, decoded from control bits 6:5
   typedef enum logic [1:0] {
      REORDER_NONE = 2'b00,
      REORDER_BYTE = 2'b01,
      REORDER_HALF = 2'b10,
      REORDER_WORD = 2'b11
   } reorder_e;

   // Which fold, if any, a data write requests
   typedef enum logic [1:0] {
      FOLD_IDLE = 2'b00,
      FOLD_BYTE = 2'b01,
      FOLD_WORD = 2'b10
   } fold_e;

   localparam int unsigned CTL_LOAD_BIT   = 0;
   localparam int unsigned CTL_ORDER_LSB  = 5;
   localparam int unsigned CTL_OUTREV_BIT = 7;

endpackage

// File: rtl/crc_csr.sv
module crc_csr
   import crc_reg_pkg::*;
#(
   parameter int unsigned           DATA_W    = 32,
   parameter int unsigned           ADDR_W    = 5,
   parameter int unsigned           OFF_DATA  = 'h00,
   parameter int unsigned           OFF_CTL   = 'h08,
   parameter int unsigned           OFF_START = 'h10,
   parameter int unsigned           OFF_POLY  = 'h14,
   parameter logic [DATA_W-1:0]     RST_START = '1,
   parameter logic [DATA_W-1:0]     RST_POLY  = DATA_W'(32'h04C1_1DB7),
   localparam int unsigned          LANES     = DATA_W / 8,
   localparam int unsigned          LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [LANES-1:0]     wr_strb,
   output logic [DATA_W-1:0]    start_val,
   output logic [DATA_W-1:0]    poly_val,
   output reorder_e             order_mode,
   output logic                 out_rev,
   output logic                 load_req,
   output fold_e                fold_kind,
   output logic [LANE_W-1:0]    fold_lane
);

   logic hit_data, hit_ctl, hit_start, hit_poly;
   logic strb_full, strb_single;

   assign hit_data  = wr_en && (wr_addr == ADDR_W'(OFF_DATA));
   assign hit_ctl   = wr_en && (wr_addr == ADDR_W'(OFF_CTL));
   assign hit_start = wr_en && (wr_addr == ADDR_W'(OFF_START));
   assign hit_poly  = wr_en && (wr_addr == ADDR_W'(OFF_POLY));

   assign strb_full   = &wr_strb;
   assign strb_single = ($countones(wr_strb) == 1);

   // Data-path request classification
   always_comb begin
      fold_kind = FOLD_IDLE;
      if (hit_data) begin
         if (strb_full)        fold_kind = FOLD_WORD;
         else if (strb_single) fold_kind = FOLD_BYTE;
      end
   end

   // Lane index of a one-hot strobe
   always_comb begin
      fold_lane = '0;
      for (int i = 0; i < int'(LANES); i++) begin
         if (wr_strb[i]) fold_lane = LANE_W'(i);
      end
   end

   // Control: all fields live in lane 0
   logic ctl_wr;
   assign ctl_wr   = hit_ctl && wr_strb[0];
   assign load_req = ctl_wr && wr_data[CTL_LOAD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         order_mode <= REORDER_NONE;
         out_rev    <= 1'b0;
      end else if (ctl_wr) begin
         order_mode <= reorder_e'(wr_data[CTL_ORDER_LSB +: 2]);
         out_rev    <= wr_data[CTL_OUTREV_BIT];
      end
   end

   // Start value and polynomial: per-lane strobed storage
   for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_val[g*8 +: 8] <= RST_START[g*8 +: 8];
            poly_val[g*8 +: 8]  <= RST_POLY[g*8 +: 8];
         end else begin
            if (hit_start && wr_strb[g]) start_val[g*8 +: 8] <= wr_data[g*8 +: 8];
            if (hit_poly  && wr_strb[g]) poly_val[g*8 +: 8]  <= wr_data[g*8 +: 8];
         end
      end
   end

endmodule

// File: rtl/crc_in_shaper.sv
module crc_in_shaper
   import crc_reg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned HALVES = DATA_W / 16
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [7:0]        byte_in,
   input  reorder_e          mode,
   output logic [DATA_W-1:0] word_out,
   output logic [7:0]        byte_out
);

   logic [DATA_W-1:0] per_byte, per_half, whole;
   logic [7:0]        byte_flip;

   for (genvar b = 0; b < int'(LANES); b++) begin : g_byte
      for (genvar k = 0; k < 8; k++) begin : g_bit
         assign per_byte[b*8 + k] = word_in[b*8 + 7 - k];
      end
   end

   for (genvar h = 0; h < int'(HALVES); h++) begin : g_half
      for (genvar k = 0; k < 16; k++) begin : g_bit
         assign per_half[h*16 + k] = word_in[h*16 + 15 - k];
      end
   end

   for (genvar k = 0; k < int'(DATA_W); k++) begin : g_whole
      assign whole[k] = word_in[DATA_W - 1 - k];
   end

   for (genvar k = 0; k < 8; k++) begin : g_bflip
      assign byte_flip[k] = byte_in[7 - k];
   end

   always_comb begin
      unique case (mode)
         REORDER_BYTE: word_out = per_byte;
         REORDER_HALF: word_out = per_half;
         REORDER_WORD: word_out = whole;
         default:      word_out = word_in;
      endcase
   end

   assign byte_out = (mode == REORDER_NONE) ? byte_in : byte_flip;

endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
   parameter int unsigned CRC_W = 32,
   parameter int unsigned DIN_W = 32
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [CRC_W-1:0] poly,
   input  logic [DIN_W-1:0] din,
   output logic [CRC_W-1:0] crc_out
);

   logic [CRC_W-1:0] work;
   logic             fb;

   // Bit-serial recurrence, unrolled: most significant input bit first
   always_comb begin
      work = crc_in;
      fb   = 1'b0;
      for (int i = int'(DIN_W) - 1; i >= 0; i--) begin
         fb   = work[CRC_W-1] ^ din[i];
         work = {work[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      crc_out = work;
   end

endmodule

// File: rtl/crc_regblock.sv
module crc_regblock
   import crc_reg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned OFF_DATA  = 'h00,
   parameter int unsigned OFF_CTL   = 'h08,
   parameter int unsigned OFF_START = 'h10,
   parameter int unsigned OFF_POLY  = 'h14,
   parameter logic [DATA_W-1:0] RST_START = '1,
   parameter logic [DATA_W-1:0] RST_POLY  = DATA_W'(32'h04C1_1DB7),
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_strb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   // Elaboration-time parameter checks
   if (DATA_W % 16 != 0 || DATA_W < 16) begin : g_bad_width
      $error("crc_regblock: DATA_W must be a nonzero multiple of 16");
   end
   if ((1 << ADDR_W) <= OFF_POLY || (1 << ADDR_W) <= OFF_START ||
       (1 << ADDR_W) <= OFF_CTL  || (1 << ADDR_W) <= OFF_DATA) begin : g_bad_addr
      $error("crc_regblock: ADDR_W too narrow for the register offsets");
   end

   logic [DATA_W-1:0] start_val, poly_val;
   reorder_e          order_mode;
   logic              out_rev;
   logic              load_req;
   fold_e             fold_kind;
   logic [LANE_W-1:0] fold_lane;

   crc_csr #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .OFF_DATA(OFF_DATA), .OFF_CTL(OFF_CTL),
      .OFF_START(OFF_START), .OFF_POLY(OFF_POLY),
      .RST_START(RST_START), .RST_POLY(RST_POLY)
   ) u_csr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .start_val(start_val), .poly_val(poly_val),
      .order_mode(order_mode), .out_rev(out_rev),
      .load_req(load_req), .fold_kind(fold_kind), .fold_lane(fold_lane)
   );

   logic [7:0]        lane_byte;
   logic [DATA_W-1:0] shaped_word;
   logic [7:0]        shaped_byte;

   assign lane_byte = wr_data[fold_lane*8 +: 8];

   crc_in_shaper #(.DATA_W(DATA_W)) u_shaper (
      .word_in(wr_data), .byte_in(lane_byte), .mode(order_mode),
      .word_out(shaped_word), .byte_out(shaped_byte)
   );

   logic [DATA_W-1:0] acc_q, acc_word, acc_byte;

   crc_fold #(.CRC_W(DATA_W), .DIN_W(DATA_W)) u_fold_word (
      .crc_in(acc_q), .poly(poly_val), .din(shaped_word), .crc_out(acc_word)
   );

   crc_fold #(.CRC_W(DATA_W), .DIN_W(8)) u_fold_byte (
      .crc_in(acc_q), .poly(poly_val), .din(shaped_byte), .crc_out(acc_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= RST_START;
      end else if (load_req) begin
         acc_q <= start_val;
      end else begin
         unique case (fold_kind)
            FOLD_WORD: acc_q <= acc_word;
            FOLD_BYTE: acc_q <= acc_byte;
            default:   acc_q <= acc_q;
         endcase
      end
   end

   // Readback path
   logic [DATA_W-1:0] acc_flip;
   for (genvar k = 0; k < int'(DATA_W); k++) begin : g_oflip
      assign acc_flip[k] = acc_q[DATA_W - 1 - k];
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFF_DATA)) begin
         rd_data = out_rev ? acc_flip : acc_q;
      end else if (rd_addr == ADDR_W'(OFF_CTL)) begin
         rd_data[CTL_ORDER_LSB +: 2] = order_mode;
         rd_data[CTL_OUTREV_BIT]     = out_rev;
      end else if (rd_addr == ADDR_W'(OFF_START)) begin
         rd_data = start_val;
      end else if (rd_addr == ADDR_W'(OFF_POLY)) begin
         rd_data = poly_val;
      end
   end

endmodule

// File: rtl/crc_regblock_chk.sv
module crc_regblock_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned OFF_DATA  = 'h00,
   parameter int unsigned OFF_CTL   = 'h08,
   parameter int unsigned OFF_START = 'h10,
   parameter int unsigned OFF_POLY  = 'h14,
   localparam int unsigned LANES    = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [LANES-1:0]  wr_strb,
   input logic [DATA_W-1:0] acc_q,
   input logic [DATA_W-1:0] start_val,
   input logic [DATA_W-1:0] poly_val,
   input logic              out_rev,
   input logic [1:0]        order_mode
);

   logic mapped, to_data, to_ctl, odd_strb;
   assign to_data  = wr_addr == ADDR_W'(OFF_DATA);
   assign to_ctl   = wr_addr == ADDR_W'(OFF_CTL);
   assign mapped   = to_data || to_ctl ||
                     wr_addr == ADDR_W'(OFF_START) || wr_addr == ADDR_W'(OFF_POLY);
   assign odd_strb = !(&wr_strb) && ($countones(wr_strb) != 1);

   assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && to_ctl && wr_strb[0] && wr_data[0]) |=> (acc_q == $past(start_val)));

   assert_mode_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && to_ctl && wr_strb[0] && !wr_data[0]) |=> $stable(acc_q));

   assert_unmapped_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> ($stable(acc_q) && $stable(start_val) &&
                              $stable(poly_val) && $stable(out_rev) && $stable(order_mode)));

   assert_odd_strobe_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && to_data && odd_strb) |=> $stable(acc_q));

   assert_idle_holds_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(acc_q));

endmodule

bind crc_regblock crc_regblock_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .OFF_DATA(OFF_DATA), .OFF_CTL(OFF_CTL),
   .OFF_START(OFF_START), .OFF_POLY(OFF_POLY)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
   .acc_q(acc_q), .start_val(start_val), .poly_val(poly_val),
   .out_rev(out_rev), .order_mode(order_mode)
);

// File: tb/crc_regblock_bench.sv
module crc_regblock_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_strb = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Bench-side model state
   logic [31:0] m_acc, m_start, m_poly;
   logic [1:0]  m_mode;
   logic        m_orev;
   int unsigned seed = 32'h1234_5678;

   crc_regblock u_crc_regblock (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] rev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   function automatic logic [31:0] shape_word(input logic [31:0] v, input logic [1:0] md);
      logic [31:0] r;
      case (md)
         2'b01: for (int i = 0; i < 4; i++) r[i*8 +: 8] = rev8(v[i*8 +: 8]);
         2'b10: for (int i = 0; i < 32; i++) r[i] = v[(i/16)*16 + 15 - (i%16)];
         2'b11: r = rev32(v);
         default: r = v;
      endcase
      return r;
   endfunction

   function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] p,
                                             input logic [31:0] d, input int nbits);
      logic [31:0] w = c;
      for (int i = nbits - 1; i >= 0; i--) begin
         if (w[31] ^ d[i]) w = (w << 1) ^ p;
         else              w = w << 1;
      end
      return w;
   endfunction

   function automatic int unsigned next_rand(input int unsigned s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   function automatic logic [31:0] exp_data();
      return m_orev ? rev32(m_acc) : m_acc;
   endfunction

   // Model update for one write, following the requirements
   task automatic model_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
      if (a == 5'h00) begin
         if (s == 4'hF) begin
            m_acc = ref_fold(m_acc, m_poly, shape_word(d, m_mode), 32);
         end else if ($countones(s) == 1) begin
            logic [7:0] b = 8'h00;
            for (int l = 0; l < 4; l++) if (s[l]) b = d[l*8 +: 8];
            if (m_mode != 2'b00) b = rev8(b);
            m_acc = ref_fold(m_acc, m_poly, {24'h0, b}, 8);
         end
      end else if (a == 5'h08) begin
         if (s[0]) begin
            m_mode = d[6:5];
            m_orev = d[7];
            if (d[0]) m_acc = m_start;
         end
      end else if (a == 5'h10) begin
         for (int l = 0; l < 4; l++) if (s[l]) m_start[l*8 +: 8] = d[l*8 +: 8];
      end else if (a == 5'h14) begin
         for (int l = 0; l < 4; l++) if (s[l]) m_poly[l*8 +: 8] = d[l*8 +: 8];
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
      @(negedge clk);
      wr_en = 1'b0; wr_strb = '0;
      model_write(a, d, s);
   endtask

   task automatic check_read(input logic [4:0] a, input logic [31:0] exp, input string req);
      rd_addr = a;
      #1;
      n_vec++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, rd_data, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      m_acc = 32'hFFFF_FFFF; m_start = 32'hFFFF_FFFF; m_poly = 32'h04C1_1DB7;
      m_mode = 2'b00; m_orev = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      check_read(5'h10, 32'hFFFF_FFFF, "R1 start");
      check_read(5'h14, 32'h04C1_1DB7, "R1 poly");
      check_read(5'h08, 32'h0000_0000, "R1 ctl");
      check_read(5'h00, 32'hFFFF_FFFF, "R1 data");
      // R8: unmapped reads
      check_read(5'h04, 32'h0, "R8 unmapped read 04");
      check_read(5'h18, 32'h0, "R8 unmapped read 18");

      // R11: published check strings through the byte path
      bus_write(5'h08, 32'h0000_00E1, 4'h1);
      // R2: load bit reads back 0
      check_read(5'h08, 32'h0000_00E0, "R2 ctl readback");
      check_read(5'h00, 32'hFFFF_FFFF, "R2 loaded value");
      for (int i = 0; i < 9; i++) bus_write(5'h00, 32'(8'h31 + i), 4'h1);
      check_read(5'h00, 32'h340B_C6D9, "R11 crc32 check");
      bus_write(5'h14, 32'h1EDC_6F41, 4'hF);
      bus_write(5'h08, 32'h0000_00E1, 4'h1);
      for (int i = 0; i < 9; i++) bus_write(5'h00, 32'(8'h31 + i) << 16, 4'h4);
      check_read(5'h00, 32'h1CF9_6D7C, "R11 crc32c check on lane 2");
      bus_write(5'h14, 32'h04C1_1DB7, 4'hF);

      // R3 R4 R5 R6 R7: all reorder/output modes, mixed word and byte pushes
      for (int md = 0; md < 4; md++) begin
         for (int orv = 0; orv < 2; orv++) begin
            seed = next_rand(seed);
            bus_write(5'h10, seed, 4'hF);
            bus_write(5'h08, {24'h0, 1'(orv), 2'(md), 5'h01}, 4'h1);
            check_read(5'h00, exp_data(), "R2 load per mode");
            for (int k = 0; k < 24; k++) begin
               seed = next_rand(seed);
               if (k % 3 == 1) begin
                  bus_write(5'h00, seed, 4'(1 << (k % 4)));
                  check_read(5'h00, exp_data(), "R4 R5 byte fold");
               end else begin
                  bus_write(5'h00, seed, 4'hF);
                  check_read(5'h00, exp_data(), "R3 R5 word fold");
               end
               if (k == 12) begin
                  // R7 / R6: flip output reversal mid-stream, accumulator kept
                  bus_write(5'h08, {24'h0, 1'(orv ^ 1), 2'(md), 5'h00}, 4'h1);
                  check_read(5'h00, exp_data(), "R7 R6 mode change keeps acc");
                  bus_write(5'h08, {24'h0, 1'(orv), 2'(md), 5'h00}, 4'h1);
               end
            end
         end
      end

      // R4: every byte value through the byte path (per-byte reorder)
      for (int v = 0; v < 256; v++) begin
         bus_write(5'h08, 32'h0000_0021, 4'h1);
         bus_write(5'h00, 32'(v) << (8 * (v % 4)), 4'(1 << (v % 4)));
         check_read(5'h00, exp_data(), "R4 byte sweep");
      end

      // R8: unmapped writes and odd strobes change nothing
      bus_write(5'h04, 32'hDEAD_BEEF, 4'hF);
      bus_write(5'h0C, 32'h0000_00FF, 4'hF);
      bus_write(5'h18, 32'h1234_5678, 4'hF);
      bus_write(5'h11, 32'h0BAD_0BAD, 4'hF);
      bus_write(5'h00, 32'hA5A5_A5A5, 4'h3);
      bus_write(5'h00, 32'hA5A5_A5A5, 4'h0);
      bus_write(5'h00, 32'hA5A5_A5A5, 4'hE);
      check_read(5'h00, exp_data(), "R8 data unchanged");
      check_read(5'h10, m_start, "R8 start unchanged");
      check_read(5'h14, m_poly, "R8 poly unchanged");
      check_read(5'h08, 32'h0000_0020, "R8 ctl unchanged");

      // R9: repeated reads have no effect
      for (int i = 0; i < 5; i++) begin
         rd_addr = 5'h00; @(negedge clk);
      end
      check_read(5'h00, exp_data(), "R9 read has no side effect");

      // R10: partial-lane writes to start value and polynomial
      bus_write(5'h10, 32'h1122_3344, 4'h5);
      check_read(5'h10, m_start, "R10 start lanes");
      bus_write(5'h14, 32'h5566_7788, 4'hA);
      check_read(5'h14, m_poly, "R10 poly lanes");
      bus_write(5'h08, 32'h0000_0001, 4'h1);
      check_read(5'h00, m_start, "R10 R2 load of partial start");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule